// File: doc/BRIEF.md
# Display Function Configuration Header

This block holds the type-0 configuration header of a display function on a PCI bus. A bus-side agent, which lies outside this block, turns configuration cycles into single-byte accesses on a plain strobe port with an 8-bit offset. The block answers reads with constant identification bytes or with stored register contents. It holds the writable registers and drives the decode enables and base addresses that the memory and I/O decoders of the function use.

The writable state is small. It holds a command byte whose two low bits gate the legacy I/O decode and the memory decodes. It also holds one byte that places a 16 MiB linear aperture, a ROM window base with its enable bit, and an interrupt line byte. Two subsystem identifiers can be written only in a vendor-specific range but read back in both that range and the standard header range. A board-level strap marks the function as built onto the motherboard. When the strap is set, the ROM registers are frozen and the ROM window never decodes.

A read strobe returns its data with a valid pulse one clock later. A write strobe updates the registers at the same clock edge, and the decode outputs follow at once. The port never stalls, so the block has no back-pressure: the agent may present one access on every cycle.

Top module: `pcicfg_disp_resp`

## Requirements
- R1: Reads return fixed identification bytes. 0x00 reads 0x2C, 0x01 reads 0x10, 0x02 reads 0xC0, 0x03 reads 0x00, 0x07 reads 0x02, 0x08 to 0x0A read 0x00, 0x0B reads 0x03 and 0x3D reads 0x01. Writes to any of these offsets have no effect.
- R2: A read strobe at one clock edge sets `acc_rvalid` for exactly the following cycle, with `acc_rdata` holding the value stored before that edge. A read and a write at the same edge therefore return the old value. `acc_rvalid` stays low when no read was made.
- R3: Offset 0x04 is a fully writable command byte. Bit 0 drives `io_dec_en` and bit 1 drives `mem_dec_en`, both valid from the write edge onward.
- R4: Offset 0x13 is a writable byte that reads back unchanged and forms bits 31:24 of `aper_base`; bits 23:0 are zero. Offsets 0x10 to 0x12 read 0x00.
- R5: `aper_dec_en` is high exactly when command bit 1 is set and the offset-0x13 byte is nonzero.
- R6: Offset 0x30 keeps only bit 0 (the ROM enable) and reads back with bits 7:1 as zero. Offset 0x32 keeps the written byte ANDed with 0xFC, and offset 0x33 keeps the whole byte. `rom_base` is {byte 0x33, byte 0x32, 16'h0000}. `rom_dec_en` is high when command bit 1, the ROM enable and a clear strap are all present.
- R7: While `onboard_strap` is high, writes to 0x30, 0x32 and 0x33 leave their stored values unchanged, and `rom_dec_en` stays low.
- R8: Offset 0x3C is a fully writable interrupt line byte, driven on `irq_line`.
- R9: Subsystem bytes are written at 0x6C to 0x6F, vendor low byte first, then vendor high, device low and device high. They read back identically at 0x6C to 0x6F and at 0x2C to 0x2F, and writes to 0x2C to 0x2F have no effect.
- R10: Every offset not named in R1 to R9 reads 0x00, and writes to it change no readable value.
- R11: After reset every writable register is zero, so all decode enables are low and both bases are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| onboard_strap | input | 1 | Function is built onto the board: ROM registers frozen, ROM decode off |
| acc_wr | input | 1 | Write strobe for one byte |
| acc_rd | input | 1 | Read strobe for one byte |
| acc_off | input | 8 | Byte offset into the header |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | One-cycle pulse after a read strobe |
| io_dec_en | output | 1 | Legacy display I/O decode enable |
| mem_dec_en | output | 1 | Memory decode enable |
| aper_dec_en | output | 1 | Linear aperture decode enable |
| aper_base | output | 32 | Linear aperture base address |
| rom_dec_en | output | 1 | Expansion ROM decode enable |
| rom_base | output | 32 | Expansion ROM window base address |
| irq_line | output | 8 | Interrupt line byte |

## Verification
The offset map is tested with all-ones writes and with sparse patterns. An all-ones write shows which bits each register keeps, such as bit 0 alone at 0x30 and the low-two-bit mask at 0x32. The sparse patterns give the subsystem bytes distinct values, so a swapped byte lane or a missing mirror shows up on readback. Writes to identification, standard subsystem and unused offsets show that read-only space really ignores stores. The bench also sets the aperture byte to zero and to nonzero, and toggles the memory bit and the strap, to tell the gating terms of the three decode enables apart.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam logic [7:0] OFF_CMD      = 8'h04;
  localparam logic [7:0] OFF_APER     = 8'h13;
  localparam logic [7:0] OFF_ROM_EN   = 8'h30;
  localparam logic [7:0] OFF_ROM_LO   = 8'h32;
  localparam logic [7:0] OFF_ROM_HI   = 8'h33;
  localparam logic [7:0] OFF_IRQ_LINE = 8'h3C;
  localparam logic [7:0] OFF_IRQ_PIN  = 8'h3D;
  localparam logic [7:0] OFF_SUB_STD  = 8'h2C;
  localparam logic [7:0] OFF_SUB_WR   = 8'h6C;

  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;
  localparam int SUB_BYTES   = 4;

  typedef struct packed {
    logic [7:0]                cmd;
    logic [7:0]                aper_hi;
    logic                      rom_en;
    logic [7:0]                rom_lo;
    logic [7:0]                rom_hi;
    logic [7:0]                irq_line;
    logic [SUB_BYTES-1:0][7:0] sub;
  } cfg_state_t;
endpackage

// File: rtl/pcicfg_regs.sv
module pcicfg_regs
  import pcicfg_pkg::*;
#(
  parameter logic [7:0] ROM_LO_MASK = 8'hFC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap,
  input  logic       wr,
  input  logic [7:0] off,
  input  logic [7:0] wdata,
  output cfg_state_t st
);
  logic rom_wr_ok;
  assign rom_wr_ok = wr && !strap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st.cmd      <= '0;
      st.aper_hi  <= '0;
      st.irq_line <= '0;
    end else if (wr) begin
      if (off == OFF_CMD)      st.cmd      <= wdata;
      if (off == OFF_APER)     st.aper_hi  <= wdata;
      if (off == OFF_IRQ_LINE) st.irq_line <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st.rom_en <= 1'b0;
      st.rom_lo <= '0;
      st.rom_hi <= '0;
    end else if (rom_wr_ok) begin
      if (off == OFF_ROM_EN) st.rom_en <= wdata[0];
      if (off == OFF_ROM_LO) st.rom_lo <= wdata & ROM_LO_MASK;
      if (off == OFF_ROM_HI) st.rom_hi <= wdata;
    end
  end

  for (genvar i = 0; i < SUB_BYTES; i++) begin : g_sub
    localparam logic [7:0] MY_OFF = OFF_SUB_WR + 8'(i);
    always_ff @(posedge clk) begin
      if (!rst_n)                    st.sub[i] <= '0;
      else if (wr && off == MY_OFF)  st.sub[i] <= wdata;
    end
  end
endmodule

// File: rtl/pcicfg_rdmux.sv
module pcicfg_rdmux
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h102C,
  parameter logic [15:0] DEVICE_ID  = 16'h00C0,
  parameter logic [7:0]  STATUS_HI  = 8'h02,
  parameter logic [7:0]  REVISION   = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h030000,
  parameter logic [7:0]  IRQ_PIN    = 8'h01
) (
  input  logic [7:0] off,
  input  cfg_state_t st,
  output logic [7:0] rdata
);
  localparam logic [5:0] SUB_STD_W = OFF_SUB_STD[7:2];
  localparam logic [5:0] SUB_WR_W  = OFF_SUB_WR[7:2];

  logic in_sub;
  assign in_sub = (off[7:2] == SUB_STD_W) || (off[7:2] == SUB_WR_W);

  always_comb begin
    rdata = 8'h00;
    if (in_sub) begin
      rdata = st.sub[off[1:0]];
    end else begin
      case (off)
        8'h00:        rdata = VENDOR_ID[7:0];
        8'h01:        rdata = VENDOR_ID[15:8];
        8'h02:        rdata = DEVICE_ID[7:0];
        8'h03:        rdata = DEVICE_ID[15:8];
        OFF_CMD:      rdata = st.cmd;
        8'h07:        rdata = STATUS_HI;
        8'h08:        rdata = REVISION;
        8'h09:        rdata = CLASS_CODE[7:0];
        8'h0A:        rdata = CLASS_CODE[15:8];
        8'h0B:        rdata = CLASS_CODE[23:16];
        OFF_APER:     rdata = st.aper_hi;
        OFF_ROM_EN:   rdata = {7'b0, st.rom_en};
        OFF_ROM_LO:   rdata = st.rom_lo;
        OFF_ROM_HI:   rdata = st.rom_hi;
        OFF_IRQ_LINE: rdata = st.irq_line;
        OFF_IRQ_PIN:  rdata = IRQ_PIN;
        default:      rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/pcicfg_decode.sv
module pcicfg_decode
  import pcicfg_pkg::*;
#(
  parameter int APER_SHIFT = 24,
  parameter int ROM_SHIFT  = 16
) (
  input  cfg_state_t  st,
  input  logic        strap,
  output logic        io_en,
  output logic        mem_en,
  output logic        aper_en,
  output logic [31:0] aper_base,
  output logic        rom_en,
  output logic [31:0] rom_base
);
  logic mem_bit;
  assign mem_bit   = st.cmd[CMD_MEM_BIT];
  assign io_en     = st.cmd[CMD_IO_BIT];
  assign mem_en    = mem_bit;
  assign aper_base = 32'(st.aper_hi) << APER_SHIFT;
  assign aper_en   = mem_bit && (st.aper_hi != 8'h00);
  assign rom_base  = 32'({st.rom_hi, st.rom_lo}) << ROM_SHIFT;
  assign rom_en    = mem_bit && st.rom_en && !strap;
endmodule

// File: rtl/pcicfg_disp_resp.sv
module pcicfg_disp_resp
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h102C,
  parameter logic [15:0] DEVICE_ID   = 16'h00C0,
  parameter logic [7:0]  STATUS_HI   = 8'h02,
  parameter logic [7:0]  REVISION    = 8'h00,
  parameter logic [23:0] CLASS_CODE  = 24'h030000,
  parameter logic [7:0]  IRQ_PIN     = 8'h01,
  parameter logic [7:0]  ROM_LO_MASK = 8'hFC,
  parameter int          APER_SHIFT  = 24,
  parameter int          ROM_SHIFT   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        onboard_strap,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  logic [7:0]  acc_off,
  input  logic [7:0]  acc_wdata,
  output logic [7:0]  acc_rdata,
  output logic        acc_rvalid,
  output logic        io_dec_en,
  output logic        mem_dec_en,
  output logic        aper_dec_en,
  output logic [31:0] aper_base,
  output logic        rom_dec_en,
  output logic [31:0] rom_base,
  output logic [7:0]  irq_line
);
  cfg_state_t st;
  logic [7:0] mux_data;

  pcicfg_regs #(.ROM_LO_MASK(ROM_LO_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap(onboard_strap),
    .wr(acc_wr), .off(acc_off), .wdata(acc_wdata), .st(st)
  );

  pcicfg_rdmux #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .STATUS_HI(STATUS_HI),
    .REVISION(REVISION), .CLASS_CODE(CLASS_CODE), .IRQ_PIN(IRQ_PIN)
  ) u_rdmux (
    .off(acc_off), .st(st), .rdata(mux_data)
  );

  pcicfg_decode #(.APER_SHIFT(APER_SHIFT), .ROM_SHIFT(ROM_SHIFT)) u_dec (
    .st(st), .strap(onboard_strap),
    .io_en(io_dec_en), .mem_en(mem_dec_en),
    .aper_en(aper_dec_en), .aper_base(aper_base),
    .rom_en(rom_dec_en), .rom_base(rom_base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
    end else begin
      acc_rvalid <= acc_rd;
      if (acc_rd) acc_rdata <= mux_data;
    end
  end

  assign irq_line = st.irq_line;
endmodule

// File: rtl/pcicfg_disp_chk.sv
module pcicfg_disp_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h102C
) (
  input logic        clk,
  input logic        rst_n,
  input logic        onboard_strap,
  input logic        acc_wr,
  input logic        acc_rd,
  input logic [7:0]  acc_off,
  input logic [7:0]  acc_wdata,
  input logic [7:0]  acc_rdata,
  input logic        acc_rvalid,
  input logic        io_dec_en,
  input logic        mem_dec_en,
  input logic        aper_dec_en,
  input logic [31:0] aper_base,
  input logic        rom_dec_en,
  input logic [31:0] rom_base
);
  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> acc_rvalid);
  // R2
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> !acc_rvalid);
  // R1
  vendor_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_off == 8'h00) |=> (acc_rdata == VENDOR_ID[7:0]));
  // R3
  cmd_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_off == 8'h04) |=>
      (io_dec_en == $past(acc_wdata[0]) && mem_dec_en == $past(acc_wdata[1])));
  // R5
  aper_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aper_dec_en |-> (mem_dec_en && aper_base != 32'h0));
  // R7
  strap_rom_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    onboard_strap |-> !rom_dec_en);
  // R7
  strap_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (onboard_strap && acc_wr && (acc_off == 8'h32 || acc_off == 8'h33)) |=> $stable(rom_base));
endmodule

bind pcicfg_disp_resp pcicfg_disp_chk #(.VENDOR_ID(VENDOR_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .onboard_strap(onboard_strap),
  .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_off(acc_off), .acc_wdata(acc_wdata),
  .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
  .io_dec_en(io_dec_en), .mem_dec_en(mem_dec_en),
  .aper_dec_en(aper_dec_en), .aper_base(aper_base),
  .rom_dec_en(rom_dec_en), .rom_base(rom_base)
);

// File: tb/pcicfg_disp_resp_tb.sv
module pcicfg_disp_resp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        onboard_strap = 1'b0;
  logic        acc_wr = 1'b0;
  logic        acc_rd = 1'b0;
  logic [7:0]  acc_off = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic        acc_rvalid;
  logic        io_dec_en, mem_dec_en, aper_dec_en, rom_dec_en;
  logic [31:0] aper_base, rom_base;
  logic [7:0]  irq_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcicfg_disp_resp u_dut (
    .clk(clk), .rst_n(rst_n), .onboard_strap(onboard_strap),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_off(acc_off), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
    .io_dec_en(io_dec_en), .mem_dec_en(mem_dec_en),
    .aper_dec_en(aper_dec_en), .aper_base(aper_base),
    .rom_dec_en(rom_dec_en), .rom_base(rom_base), .irq_line(irq_line)
  );

  // Vector: {is_write, requirement number, offset, write data or expected read}
  localparam int NV = 44;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd1, 8'h00, 8'h2C}, {1'b0, 4'd1, 8'h01, 8'h10},   // R1
    {1'b0, 4'd1, 8'h02, 8'hC0}, {1'b0, 4'd1, 8'h03, 8'h00},   // R1
    {1'b0, 4'd1, 8'h07, 8'h02}, {1'b0, 4'd1, 8'h08, 8'h00},   // R1
    {1'b0, 4'd1, 8'h0A, 8'h00}, {1'b0, 4'd1, 8'h0B, 8'h03},   // R1
    {1'b0, 4'd1, 8'h3D, 8'h01},                               // R1
    {1'b0, 4'd10, 8'h05, 8'h00}, {1'b0, 4'd10, 8'hFF, 8'h00}, // R10
    {1'b0, 4'd4, 8'h10, 8'h00}, {1'b0, 4'd4, 8'h12, 8'h00},   // R4
    {1'b1, 4'd3, 8'h04, 8'hFF}, {1'b0, 4'd3, 8'h04, 8'hFF},   // R3
    {1'b1, 4'd4, 8'h13, 8'hA5}, {1'b0, 4'd4, 8'h13, 8'hA5},   // R4
    {1'b1, 4'd6, 8'h30, 8'hFF}, {1'b0, 4'd6, 8'h30, 8'h01},   // R6
    {1'b1, 4'd6, 8'h32, 8'hFF}, {1'b0, 4'd6, 8'h32, 8'hFC},   // R6
    {1'b1, 4'd6, 8'h33, 8'h12}, {1'b0, 4'd6, 8'h33, 8'h12},   // R6
    {1'b1, 4'd8, 8'h3C, 8'h0B}, {1'b0, 4'd8, 8'h3C, 8'h0B},   // R8
    {1'b1, 4'd9, 8'h6C, 8'h34}, {1'b1, 4'd9, 8'h6D, 8'h12},   // R9
    {1'b1, 4'd9, 8'h6E, 8'h78}, {1'b1, 4'd9, 8'h6F, 8'h56},   // R9
    {1'b0, 4'd9, 8'h2C, 8'h34}, {1'b0, 4'd9, 8'h2D, 8'h12},   // R9
    {1'b0, 4'd9, 8'h2E, 8'h78}, {1'b0, 4'd9, 8'h2F, 8'h56},   // R9
    {1'b0, 4'd9, 8'h6C, 8'h34}, {1'b0, 4'd9, 8'h6F, 8'h56},   // R9
    {1'b1, 4'd9, 8'h2C, 8'hAA}, {1'b0, 4'd9, 8'h2C, 8'h34},   // R9
    {1'b0, 4'd9, 8'h6C, 8'h34},                               // R9
    {1'b1, 4'd1, 8'h00, 8'h55}, {1'b0, 4'd1, 8'h00, 8'h2C},   // R1
    {1'b1, 4'd10, 8'h50, 8'h77}, {1'b0, 4'd10, 8'h50, 8'h00}, // R10
    {1'b1, 4'd10, 8'h05, 8'h77}, {1'b0, 4'd10, 8'h05, 8'h00}  // R10
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_off = off; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] off, output logic [7:0] d, output logic v);
    @(negedge clk);
    acc_rd = 1'b1; acc_off = off;
    @(negedge clk);
    acc_rd = 1'b0;
    d = acc_rdata; v = acc_rvalid;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "io_dec_en", io_dec_en, 0);
    chk("R11", "mem_dec_en", mem_dec_en, 0);
    chk("R11", "aper_dec_en", aper_dec_en, 0);
    chk("R11", "rom_dec_en", rom_dec_en, 0);
    chk("R11", "aper_base", aper_base, 0);
    chk("R11", "rom_base", rom_base, 0);
    chk("R11", "irq_line", irq_line, 0);
    chk("R2", "rvalid idle", acc_rvalid, 0);
    do_rd(8'h6D, d, v);
    chk("R11", "sub byte", d, 0);
    chk("R2", "rvalid pulse", v, 1);
    @(negedge clk);
    chk("R2", "rvalid drops", acc_rvalid, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        do_wr(VEC[i][15:8], VEC[i][7:0]);
      end else begin
        do_rd(VEC[i][15:8], d, v);
        checks++;
        if (d !== VEC[i][7:0] || v !== 1'b1) begin
          errors++;
          $display("FAIL R%0d read 0x%0h: actual 0x%0h expected 0x%0h", VEC[i][19:16],
                   VEC[i][15:8], d, VEC[i][7:0]);
        end
      end
    end

    // R3 R5 R6 R8 decode outputs after the table
    chk("R3", "io_dec_en", io_dec_en, 1);
    chk("R3", "mem_dec_en", mem_dec_en, 1);
    chk("R4", "aper_base", aper_base, 32'hA500_0000);
    chk("R5", "aper_dec_en", aper_dec_en, 1);
    chk("R6", "rom_base", rom_base, 32'h12FC_0000);
    chk("R6", "rom_dec_en", rom_dec_en, 1);
    chk("R8", "irq_line", irq_line, 8'h0B);

    // R2 read and write at the same edge return the old value
    @(negedge clk);
    acc_rd = 1'b1; acc_wr = 1'b1; acc_off = 8'h3C; acc_wdata = 8'h99;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    chk("R2", "old value on collision", acc_rdata, 8'h0B);
    chk("R8", "irq_line new", irq_line, 8'h99);

    // R5 zero aperture byte disables the aperture
    do_wr(8'h13, 8'h00);
    chk("R5", "aper off at zero base", aper_dec_en, 0);
    do_wr(8'h13, 8'h01);
    chk("R5", "aper on at nonzero", aper_dec_en, 1);
    // R3 R5 R6 memory bit gates memory decodes
    do_wr(8'h04, 8'h01);
    chk("R3", "io only", io_dec_en, 1);
    chk("R3", "mem off", mem_dec_en, 0);
    chk("R5", "aper off without mem", aper_dec_en, 0);
    chk("R6", "rom off without mem", rom_dec_en, 0);
    do_wr(8'h04, 8'h02);
    chk("R3", "io off", io_dec_en, 0);
    chk("R6", "rom back on", rom_dec_en, 1);

    // R7 strap locks ROM registers and decode
    onboard_strap = 1'b1;
    @(negedge clk);
    chk("R7", "rom_dec_en under strap", rom_dec_en, 0);
    do_wr(8'h32, 8'h00);
    do_wr(8'h33, 8'h00);
    do_wr(8'h30, 8'h00);
    chk("R7", "rom_base held", rom_base, 32'h12FC_0000);
    do_rd(8'h30, d, v);
    chk("R7", "rom enable held", d, 8'h01);
    onboard_strap = 1'b0;
    @(negedge clk);
    chk("R7", "rom decode after strap release", rom_dec_en, 1);
    do_wr(8'h30, 8'h00);
    chk("R6", "rom disable write", rom_dec_en, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule